// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when a dynamic memory controller should send AUTO REFRESH commands. An interval timer expires once per average refresh period. The period is the full refresh window divided by the number of rows: 64 ms over 4096 rows, or 15.625 µs. Each expiry adds one to a backlog of owed refreshes. While the backlog is non-zero, the block asks the controller for a refresh. When the backlog reaches its ceiling of eight, it raises an urgent request as well. The controller can therefore put refreshes off while the bus is busy and catch up later with a back-to-back burst.

The controller pulses `ref_done` in the cycle it issues AUTO REFRESH. A pulse counts only while `ref_req` is high. After each accepted refresh the block holds its request low for the recovery time tRFC, so refreshes in a burst keep their spacing. A separate gap watchdog measures the time since the last accepted refresh. It sets a sticky error once that time exceeds eight average intervals.

The state machine has four states:
- `ST_IDLE`: nothing is owed.
- `ST_PEND`: the backlog is between one and seven, and a request is raised.
- `ST_URGENT`: the backlog is at the ceiling, and both requests are raised.
- `ST_RECOVER`: tRFC is being waited out after an accepted refresh.

The state machine has these transitions:
- IDLE→PEND when the backlog becomes non-zero.
- PEND→URGENT when the backlog reaches the ceiling.
- PEND/URGENT→RECOVER on an accepted refresh.
- RECOVER→IDLE, PEND or URGENT, chosen by the backlog, when the recovery count runs out.
- URGENT→PEND when an interval expiry pushes the count back below the ceiling. This cannot happen in practice, because expiries only add.

Cycle counts are derived from `CLK_HZ`:
- The interval count rounds down, so refreshes are never late.
- The recovery count rounds up.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is asserted, and right after it is released, `ref_req`, `ref_urgent` and `gap_err` are 0 and `pend_cnt` is 0.
- R2: `pend_cnt` increases by one every REFI_CYC clock edges, with REFI_CYC = floor(CLK_HZ·REFI_NS/10^9). The first increase takes effect on edge REFI_CYC after reset release.
- R3: `ref_req` is 1 exactly when `pend_cnt` is non-zero and no recovery window is running.
- R4: A `ref_done` pulse sampled while `ref_req` is 1 is accepted and lowers `pend_cnt` by one at that edge. If an interval expiry falls on the same edge, the count stays unchanged.
- R5: A `ref_done` pulse while `ref_req` is 0 has no effect on `pend_cnt`, on the request outputs or on the gap watchdog.
- R6: After an accepted refresh, `ref_req` and `ref_urgent` stay 0 for TRFC_CYC−1 cycles. TRFC_CYC = ceil(CLK_HZ·TRFC_NS/10^9), and TRFC_CYC must be at least 2. Accepted refreshes are therefore at least TRFC_CYC cycles apart.
- R7: `ref_urgent` is 1 exactly when `pend_cnt` equals MAX_PEND (8) and no recovery window is running.
- R8: `pend_cnt` never exceeds MAX_PEND. An expiry at the ceiling with no accepted refresh leaves it at MAX_PEND.
- R9: `gap_err` becomes 1 after GAP_CYC+1 consecutive edges with no accepted refresh, counted from reset or from the last acceptance. GAP_CYC = MAX_PEND·REFI_CYC. Once set, `gap_err` stays 1 until reset.
- R10: With `ref_done` held high and the backlog at the ceiling, eight refreshes are accepted within 8·TRFC_CYC−2 edges, each TRFC_CYC cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_done | input | 1 | Controller issued AUTO REFRESH this cycle |
| ref_req | output | 1 | A refresh is owed and may be issued |
| ref_urgent | output | 1 | Backlog is at its ceiling; refresh must go next |
| gap_err | output | 1 | Sticky: gap between refreshes exceeded the limit |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of owed refreshes (debug) |

## Verification
If the interval counter or the backlog goes wrong, `pend_cnt` and `ref_req` depart from the arithmetic expectation at the next expiry edge. That edge is at most REFI_CYC cycles away. A recovery count that is off by one shows in the very next grant pattern: `ref_req` returns one cycle early or late after acceptance. A wrong watchdog limit shows as `gap_err` rising on the wrong edge of a no-grant run, or never rising at all. The bench follows every output on every cycle, so any such fault is reported on the edge where it first appears.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_URGENT,
        ST_RECOVER
    } rs_state_t;
endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(PERIOD - 1);
        end else if (cnt == '0) begin
            cnt <= W'(PERIOD - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/refsched_recovery_timer.sv
module refsched_recovery_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int W = (CYCLES > 2) ? $clog2(CYCLES - 1) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(CYCLES - 2);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    // R6
    recovery_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (CYCLES >= 2));
endmodule

// File: rtl/refsched_gap_watchdog.sv
module refsched_gap_watchdog #(
    parameter int LIMIT = 12496
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic err
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (kick) begin
            cnt <= '0;
        end else if (cnt == W'(LIMIT)) begin
            err <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int REFI_NS  = 15625,
    parameter int TRFC_NS  = 60,
    parameter int MAX_PEND = 8,
    localparam int PW      = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_done,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          gap_err,
    output logic [PW-1:0] pend_cnt
);
    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
    localparam int REFI_CYC = int'((64'(CLK_HZ) * 64'(REFI_NS)) / NS_PER_S);
    localparam int TRFC_CYC = int'((64'(CLK_HZ) * 64'(TRFC_NS) + NS_PER_S - 64'd1) / NS_PER_S);
    localparam int GAP_CYC  = MAX_PEND * REFI_CYC;

    rs_state_t     state, state_nx;
    logic [PW-1:0] pend, pend_nx;
    logic          tick, accept, rec_last;

    refsched_interval_timer #(.PERIOD(REFI_CYC)) i_interval (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    refsched_recovery_timer #(.CYCLES(TRFC_CYC)) i_recovery (
        .clk(clk), .rst_n(rst_n), .start(accept), .last(rec_last)
    );

    refsched_gap_watchdog #(.LIMIT(GAP_CYC)) i_watchdog (
        .clk(clk), .rst_n(rst_n), .kick(accept), .err(gap_err)
    );

    function automatic rs_state_t decode(input logic [PW-1:0] n);
        if (n == '0)                 return ST_IDLE;
        else if (n == PW'(MAX_PEND)) return ST_URGENT;
        else                         return ST_PEND;
    endfunction

    assign accept = ref_done && ((state == ST_PEND) || (state == ST_URGENT));

    always_comb begin
        pend_nx = pend;
        if (tick && !accept && (pend != PW'(MAX_PEND))) begin
            pend_nx = pend + 1'b1;
        end else if (!tick && accept) begin
            pend_nx = pend - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:             state_nx = decode(pend_nx);
            ST_PEND, ST_URGENT:  state_nx = accept ? ST_RECOVER : decode(pend_nx);
            ST_RECOVER:          state_nx = rec_last ? decode(pend_nx) : ST_RECOVER;
            default:             state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
        end
    end

    always_comb begin
        ref_req    = 1'b0;
        ref_urgent = 1'b0;
        unique case (state)
            ST_PEND:   ref_req = 1'b1;
            ST_URGENT: begin
                ref_req    = 1'b1;
                ref_urgent = 1'b1;
            end
            default: ;
        endcase
    end

    assign pend_cnt = pend;

    // R8
    pend_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(MAX_PEND));

    // R6
    recover_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!ref_req && !ref_urgent));

    // R7
    urgent_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req && pend == PW'(MAX_PEND)));

    // R5
    ignored_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_done && !ref_req && !tick) |=> $stable(pend));

    // R3
    req_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (pend != '0));
endmodule

// File: tb/test_refresh_scheduler.sv
module test_refresh_scheduler;
    localparam int CLK_PERIOD = 10;
    localparam int P_CLK_HZ   = 1_000_000;
    localparam int P_REFI_NS  = 10500;
    localparam int P_TRFC_NS  = 2500;
    localparam int P_MAX      = 8;
    localparam int REFI = int'((64'(P_CLK_HZ) * 64'(P_REFI_NS)) / 64'd1000000000);
    localparam int TRFC = int'((64'(P_CLK_HZ) * 64'(P_TRFC_NS) + 64'd999999999) / 64'd1000000000);
    localparam int GAP  = P_MAX * REFI;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_done = 1'b0;
    logic       ref_req, ref_urgent, gap_err;
    logic [3:0] pend_cnt;

    int nchk = 0;
    int nerr = 0;
    int k = 0;
    int m_pend, m_rec, m_gap, m_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    refresh_scheduler #(
        .CLK_HZ(P_CLK_HZ), .REFI_NS(P_REFI_NS), .TRFC_NS(P_TRFC_NS), .MAX_PEND(P_MAX)
    ) i_refresh_scheduler (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done),
        .ref_req(ref_req), .ref_urgent(ref_urgent),
        .gap_err(gap_err), .pend_cnt(pend_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s edge=%0d actual=%0d expected=%0d", tag, k, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R4 R8 pend_cnt", int'(pend_cnt), m_pend);
        chk("R3 R5 R6 ref_req", int'(ref_req), int'(m_pend != 0 && m_rec == 0));
        chk("R7 ref_urgent", int'(ref_urgent), int'(m_pend == P_MAX && m_rec == 0));
        chk("R9 gap_err", int'(gap_err), m_err);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", int'(ref_req), 0);
        chk("R1 urgent in reset", int'(ref_urgent), 0);
        chk("R1 err in reset", int'(gap_err), 0);
        chk("R1 pend in reset", int'(pend_cnt), 0);
        rst_n = 1'b1;
        k = 0;
        m_pend = 0; m_rec = 0; m_gap = 0; m_err = 0;
        compare_all();
    endtask

    // one clock edge with ref_done = d, then model update and compare
    task automatic step(input logic d, output logic accepted);
        logic acc, tk;
        ref_done = d;
        acc = d && (m_pend != 0) && (m_rec == 0);
        @(posedge clk);
        k++;
        tk = (k % REFI == 0);
        if (tk && !acc && m_pend != P_MAX) m_pend++;
        else if (!tk && acc) m_pend--;
        if (acc) m_rec = TRFC - 1;
        else if (m_rec > 0) m_rec--;
        if (acc) m_gap = 0;
        else if (m_gap == GAP) m_err = 1;
        else m_gap++;
        accepted = acc;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic a;
        logic [15:0] lfsr;
        int burst;
        int last_acc;

        // no grants: backlog growth, saturation, urgent, gap error
        do_reset();
        for (int i = 0; i < GAP + 20; i++) step(1'b0, a);
        chk("R8 saturated", int'(pend_cnt), P_MAX);
        chk("R9 error after gap", int'(gap_err), 1);

        // grant held high from reset: catch every refresh at once
        do_reset();
        for (int i = 0; i < 200; i++) step(1'b1, a);

        // build up a full backlog, then burst
        do_reset();
        for (int i = 0; i < GAP; i++) step(1'b0, a);
        chk("R7 urgent at ceiling", int'(ref_urgent), 1);
        burst = 0;
        last_acc = -100;
        for (int i = 0; i < 8 * TRFC - 2; i++) begin
            step(1'b1, a);
            if (a) begin
                // R10 spacing between accepted refreshes
                if (last_acc >= 0) chk("R10 spacing", k - last_acc, TRFC);
                last_acc = k;
                burst++;
            end
        end
        chk("R10 burst count", burst, 8);
        chk("R9 no error when caught up", int'(gap_err), 0);

        // sparse and dense pseudo-random grants
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[3], a);
        end
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(&lfsr[3:0], a);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule